// File: doc/BRIEF.md
# Four-Slot TDM Serial Channel Port

This block connects a device to a shared 2048 kbit/s time-division serial stream. The stream is clocked at twice the bit rate, and an active-low frame pulse aligns it. Each frame holds 32 eight-bit timeslots. The block owns only the first four, which carry, in fixed order, a signalling channel (D), a control/status channel (C) and two bearer channels (B1, B2).

On the transmit side, four parallel bytes are captured when the frame pulse is seen. They are shifted out MSB first through slots 0 to 3. A separate output-enable marks those slots so that a pad can float the line for the other 28 slots. On the receive side, the same four slots are shifted in and handed over as four parallel bytes with a one-cycle strobe.

A delayed frame pulse at the end of slot 3 lets a second device on the same stream start its own slots. A half-frame select input is latched on the falling clock edge while the frame pulse is low. A mode input chooses a 16 kbit/s or 64 kbit/s signalling channel. In 16 kbit/s mode the six unused D bits are forced to 1.

Top module: `tdm_chan_port`

## Requirements
- R1: After reset, and until the first frame pulse, `sdo_oe` is 0, `sdo` is 1, `dfp_n` is 1, `rx_valid` is 0 and `half` is 0.
- R2: `fp_n` low at a rising edge makes the next cycle cycle 0 of a frame. Every bit cell lasts two cycles. A frame has 256 bit cells (512 cycles). A frame pulse in the middle of a frame realigns the count to cycle 0.
- R3: Bit n of the frame (n = 0..31) is driven on `sdo` during cycles 2n and 2n+1. The bits come in slot order D, C, B1, B2, each byte MSB first.
- R4: The transmit bytes are latched at the rising edge that samples `fp_n` low. Changes to `tx_*` later in the frame do not alter what is sent in that frame.
- R5: `sdo_oe` is 1 exactly during cycles 0 to 63 of a frame and 0 during slots 4 to 31. While it is 0, `sdo` is 1.
- R6: `sdi` is sampled at the rising edge that ends each bit cell of slots 0 to 3. Received bytes are assembled MSB first and appear on `rx_d`, `rx_c`, `rx_b1` and `rx_b2` in cycle 64. `rx_valid` is 1 for that single cycle.
- R7: `dfp_n` is 0 for exactly one cycle, cycle 63, the last cycle of slot 3.
- R8: With `d_mode64` = 0, bits 5..0 of the D slot are forced to 1, both on `sdo` and on `rx_d`, and bits 7..6 pass unchanged. With `d_mode64` = 1, all eight D bits pass.
- R9: `half` takes the value of `hsel` at each falling clock edge where `fp_n` is low. It holds that value until the next such edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, two cycles per bit cell |
| rst_n | input | 1 | Asynchronous active-low reset |
| fp_n | input | 1 | Active-low frame pulse |
| hsel | input | 1 | Half-frame select, 0 = first half, 1 = second half |
| d_mode64 | input | 1 | 1 = 64 kbit/s D channel, 0 = 16 kbit/s |
| sdi | input | 1 | Serial stream input |
| tx_d | input | 8 | D byte to send |
| tx_c | input | 8 | C byte to send |
| tx_b1 | input | 8 | B1 byte to send |
| tx_b2 | input | 8 | B2 byte to send |
| sdo | output | 1 | Serial stream output data |
| sdo_oe | output | 1 | Output enable for the serial pad, high in slots 0 to 3 |
| dfp_n | output | 1 | Active-low delayed frame pulse |
| rx_d | output | 8 | Received D byte |
| rx_c | output | 8 | Received C byte |
| rx_b1 | output | 8 | Received B1 byte |
| rx_b2 | output | 8 | Received B2 byte |
| rx_valid | output | 1 | One-cycle strobe for the received bytes |
| half | output | 1 | Latched half-frame select |

## Verification
A slip in the cycle counter moves the serial bits sideways. This shows up within the first bit cell as a wrong `sdo` level, and within 64 cycles as an early or late `dfp_n` or `sdo_oe` edge. A fault in the transmit shadow register shows in the same frame as a wrong bit in a known slot. A fault in the receive shift path shows in cycle 64 as a wrong byte or a missing strobe. A bad D-fill shows in the low six bits of the D slot, both on the line and on `rx_d`, in the first frame sent in 16 kbit/s mode.

// File: rtl/tdm_chan_port.sv
module tdm_chan_port #(
  parameter int SLOTS = 32,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fp_n,
  input  logic         hsel,
  input  logic         d_mode64,
  input  logic         sdi,
  input  logic [W-1:0] tx_d,
  input  logic [W-1:0] tx_c,
  input  logic [W-1:0] tx_b1,
  input  logic [W-1:0] tx_b2,
  output logic         sdo,
  output logic         sdo_oe,
  output logic         dfp_n,
  output logic [W-1:0] rx_d,
  output logic [W-1:0] rx_c,
  output logic [W-1:0] rx_b1,
  output logic [W-1:0] rx_b2,
  output logic         rx_valid,
  output logic         half
);
  localparam int NACT  = 4;
  localparam int CPB   = 2;
  localparam int FCYC  = SLOTS * W * CPB;
  localparam int ABITS = NACT * W;
  localparam int ACYC  = ABITS * CPB;
  localparam int CW    = $clog2(FCYC);
  localparam int AW    = $clog2(ABITS);

  logic [CW-1:0]    cnt;
  logic             run;
  logic [ABITS-1:0] txs;
  logic [ABITS-1:0] rxs;

  wire [CW-2:0]    bidx  = cnt[CW-1:1];
  wire             act   = run && (bidx < (CW-1)'(ABITS));
  wire             last  = run && (cnt == CW'(ACYC - 1));
  wire [W-1:0]     dfill = d_mode64 ? '0 : {2'b00, {(W-2){1'b1}}};
  wire [ABITS-1:0] shv   = txs << bidx[AW-1:0];
  wire [ABITS-1:0] word  = {rxs[ABITS-2:0], sdi};

  assign sdo    = act ? shv[ABITS-1] : 1'b1;
  assign sdo_oe = act;
  assign dfp_n  = ~last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      run <= 1'b0;
      txs <= '0;
    end else if (!fp_n) begin
      cnt <= '0;
      run <= 1'b1;
      txs <= {tx_d | dfill, tx_c, tx_b1, tx_b2};
    end else if (run) begin
      cnt <= (cnt == CW'(FCYC - 1)) ? '0 : cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxs      <= '0;
      rx_d     <= '0;
      rx_c     <= '0;
      rx_b1    <= '0;
      rx_b2    <= '0;
      rx_valid <= 1'b0;
    end else begin
      if (act && cnt[0]) rxs <= word;
      rx_valid <= last;
      if (last) begin
        rx_d  <= word[4*W-1:3*W] | dfill;
        rx_c  <= word[3*W-1:2*W];
        rx_b1 <= word[2*W-1:W];
        rx_b2 <= word[W-1:0];
      end
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n)     half <= 1'b0;
    else if (!fp_n) half <= hsel;
  end
endmodule

// File: rtl/tdm_chan_port_chk.sv
module tdm_chan_port_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         fp_n,
  input logic         d_mode64,
  input logic         sdo_oe,
  input logic         dfp_n,
  input logic         rx_valid,
  input logic [W-1:0] rx_d
);
  // R6
  rx_strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R7
  dfp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dfp_n |=> dfp_n);

  // R6
  dfp_then_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dfp_n |=> rx_valid);

  // R5
  release_after_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dfp_n && fp_n) |=> !sdo_oe);

  // R2
  frame_start_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fp_n |=> sdo_oe);

  // R8
  d_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !$past(d_mode64)) |-> (rx_d[W-3:0] == {(W-2){1'b1}}));
endmodule

bind tdm_chan_port tdm_chan_port_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fp_n(fp_n), .d_mode64(d_mode64),
  .sdo_oe(sdo_oe), .dfp_n(dfp_n), .rx_valid(rx_valid), .rx_d(rx_d)
);

// File: tb/tdm_chan_port_test.sv
module tdm_chan_port_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fp_n = 1'b1, hsel = 1'b0, d_mode64 = 1'b1, sdi = 1'b1;
  logic [7:0] tx_d = '0, tx_c = '0, tx_b1 = '0, tx_b2 = '0;
  logic sdo, sdo_oe, dfp_n, rx_valid, half;
  logic [7:0] rx_d, rx_c, rx_b1, rx_b2;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] expq[$];

  always #4 clk = ~clk;

  tdm_chan_port uut (
    .clk(clk), .rst_n(rst_n), .fp_n(fp_n), .hsel(hsel), .d_mode64(d_mode64),
    .sdi(sdi), .tx_d(tx_d), .tx_c(tx_c), .tx_b1(tx_b1), .tx_b2(tx_b2),
    .sdo(sdo), .sdo_oe(sdo_oe), .dfp_n(dfp_n), .rx_d(rx_d), .rx_c(rx_c),
    .rx_b1(rx_b1), .rx_b2(rx_b2), .rx_valid(rx_valid), .half(half)
  );

  task automatic check(input bit ok, input string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s", msg);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  function automatic logic [7:0] fill(input logic [7:0] d, input logic m64);
    return m64 ? d : (d | 8'h3F);
  endfunction

  // Runs ncyc cycles of one frame; checks line outputs, pushes the expected receive word.
  task automatic frame(input logic [31:0] txw, input logic [31:0] rxw,
                       input logic m64, input logic h, input int ncyc);
    logic [31:0] sent;
    sent = {fill(txw[31:24], m64), txw[23:0]};
    tick();
    {tx_d, tx_c, tx_b1, tx_b2} = txw;
    d_mode64 = m64;
    hsel = h;
    fp_n = 1'b0;
    if (ncyc > 64) expq.push_back({fill(rxw[31:24], m64), rxw[23:0]});
    for (int k = 0; k < ncyc; k++) begin
      tick();
      if (k == 0) begin
        fp_n = 1'b1;
        {tx_d, tx_c, tx_b1, tx_b2} = ~txw; // R4: late change must not reach the line
        hsel = ~h;
        check(half === h, $sformatf("R9 half got %b exp %b", half, h));
      end
      if (k < 64) sdi = rxw[31 - k/2];
      else sdi = 1'b0;
      if (k < 64 || k == 200 || k == 511)
        check(sdo_oe === (k < 64), $sformatf("R5 sdo_oe k=%0d got %b exp %b", k, sdo_oe, k < 64));
      if (k < 64)
        check(sdo === sent[31 - k/2],
              $sformatf("R3/R4/R8 sdo k=%0d got %b exp %b", k, sdo, sent[31 - k/2]));
      else if (k == 300)
        check(sdo === 1'b1, $sformatf("R5 idle sdo got %b exp 1", sdo));
      if (k >= 60 && k <= 66)
        check(dfp_n === (k != 63), $sformatf("R7 dfp_n k=%0d got %b exp %b", k, dfp_n, k != 63));
      if (k == 300)
        check(half === h, $sformatf("R9 half hold got %b exp %b", half, h));
    end
  endtask

  // Scoreboard monitor for the received words (R6, R8)
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && rx_valid) begin
        if (expq.size() == 0)
          check(1'b0, $sformatf("R6 unexpected rx_valid got %h exp none", {rx_d, rx_c, rx_b1, rx_b2}));
        else begin
          logic [31:0] e;
          e = expq.pop_front();
          check({rx_d, rx_c, rx_b1, rx_b2} === e,
                $sformatf("R6/R8 rx word got %h exp %h", {rx_d, rx_c, rx_b1, rx_b2}, e));
        end
      end
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog expired got hang exp finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    for (int i = 0; i < 20; i++) begin
      tick();
      check(sdo_oe === 1'b0 && sdo === 1'b1 && dfp_n === 1'b1 && rx_valid === 1'b0 && half === 1'b0,
            $sformatf("R1 idle got oe=%b sdo=%b dfp=%b rv=%b half=%b exp 0 1 1 0 0",
                      sdo_oe, sdo, dfp_n, rx_valid, half));
    end
    frame(32'hA5C3_0F81, 32'h1234_5678, 1'b1, 1'b0, 512);
    frame(32'hFFFF_0000, 32'h0000_FFFF, 1'b1, 1'b1, 512);
    frame(32'h0055_AA01, 32'h80C0_E0F0, 1'b0, 1'b0, 512); // R8 16 kbit/s fill
    frame(32'h3C96_6913, 32'h4000_0001, 1'b0, 1'b1, 512);
    // R2: frame pulse mid-frame realigns
    frame(32'hDEAD_BEEF, 32'h0, 1'b1, 1'b0, 40);
    frame(32'h7E81_18E7, 32'hCAFE_F00D, 1'b1, 1'b1, 512);
    frame(32'h0123_4567, 32'h89AB_CDEF, 1'b1, 1'b0, 512);
    repeat (4) tick();
    check(expq.size() == 0, $sformatf("R6 pending rx words got %0d exp 0", expq.size()));
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule